// File: doc/BRIEF.md
# I2C Register Access Master

This block is a single-master I2C engine that carries out one complete register transaction for each command it is given. There are three transaction types. A probe sends only the device address to see whether a target answers. A register write sends an address, a register offset and one data byte. A register read sends the address and offset, then issues a repeated START and reads one byte back. The user presents a 7-bit device address, an 8-bit register offset and an 8-bit write value on a simple command port. The block replies with a one-cycle completion pulse, a failure flag and, after a read, the byte it received.

Both bus lines are open-drain. The block drives each physical pin through an output-enable: asserting the enable pulls the pin low, and releasing it lets an external pull-up take the pin high. A configuration input exchanges which physical pin acts as clock and which acts as data, on the drive side and on the sense side alike. This covers boards where the two lines are crossed. All bus timing is built from a quarter-bit tick whose length is set by a divider input. At 100 kbit/s the bit period is 10 µs, so the quarter is 2.5 µs.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both `pin_a_oe` and `pin_b_oe` are 0, so both lines are released.
- R2: With `swap_pins`=0, pin A is the clock line and pin B is the data line. With `swap_pins`=1 the roles are exchanged, for both the output-enable and the sensed input.
- R3: One quarter lasts `quarter_div`+1 clock cycles, with `quarter_div` at least 3. Each bit sets the data line while the clock is low, waits one quarter, holds the clock high for two quarters, then holds it low for one quarter.
- R4: A START releases both lines for four quarters. It then pulls the data line low while the clock is high, and one quarter later pulls the clock low. Outside START and STOP, the data line changes only while the clock is low.
- R5: A STOP pulls the data line low with the clock low and waits one quarter. It then releases the clock and, two quarters later, releases the data line. One quarter after that, `done` pulses.
- R6: Bytes go out most significant bit first. On the ninth clock of each byte the master releases the data line, and a low level sampled there counts as ACK.
- R7: `cmd_op`=0 (probe) sends START, {address, 0} and STOP. `fail` is 0 only if that byte was ACKed.
- R8: `cmd_op`=1 (write) sends START, {address, 0}, the offset, the data byte and STOP, and each byte must be ACKed.
- R9: `cmd_op`=2 (read) sends START, {address, 0}, the offset, a repeated START and {address, 1}. It then reads one byte with the data line released, answers NACK (line high) on the ninth clock, sends STOP and presents the byte on `rdata`.
- R10: If any byte the master sends is not ACKed, the rest of the transaction is skipped. STOP is still sent, `fail` is 1, and `rdata` keeps its previous value.
- R11: A command is taken only when `cmd_valid`=1, `enable`=1 and `busy`=0. `busy` rises in the cycle after acceptance and falls in the cycle in which the one-cycle `done` pulse is high. Commands presented while busy are ignored.
- R12: Driving `enable` to 0 abandons any transaction. Both output-enables are 0 within two cycles, `busy` falls, and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; 0 aborts and releases the bus |
| swap_pins | input | 1 | 1 exchanges the clock and data roles of pins A and B |
| quarter_div | input | DIV_W | Quarter-bit length in clock cycles, minus one |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 probe, 1 register write, 2 register read |
| cmd_dev | input | 7 | Target device address |
| cmd_reg | input | 8 | Register offset |
| cmd_wdata | input | 8 | Write data |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last transaction saw a missing ACK |
| rdata | output | 8 | Byte from the last successful read |
| pin_a_oe | output | 1 | Pull pin A low |
| pin_b_oe | output | 1 | Pull pin B low |
| pin_a_in | input | 1 | Sensed level of pin A |
| pin_b_in | input | 1 | Sensed level of pin B |

## Verification
The hardest situation to reach is a missing ACK in the middle of a transaction, after the address has already been accepted. Reaching it needs a target that takes part correctly up to a chosen byte and then stays silent. The bench therefore includes a behavioural bus target that can be told to withhold its ACK on a given byte, and checks that the register offset NACK ends in STOP without writing the register. A second hard case is a repeated START. Here the clock rises from low while the data line is released, and the target must switch to driving the data line right after it ACKs the read address. The bench's target follows START and STOP edges on the resolved lines and measures every clock-high width and START/STOP spacing, using both crossed and straight wiring.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_STOP
  } phase_e;

  typedef enum logic [2:0] {
    K_START,
    K_ADDR_W,
    K_ADDR_R,
    K_REG,
    K_DATA,
    K_RECV,
    K_STOP
  } step_e;

  // quarters per bus element; START carries one extra quarter with both lines low
  localparam int START_QTRS = 6;
  localparam int BIT_QTRS   = 4;
  localparam int STOP_QTRS  = 4;
  localparam int BYTE_BITS  = 8;

  // ordered list of bus elements for each transaction type
  function automatic step_e step_of(input op_e op, input logic [2:0] idx);
    step_e k;
    k = K_STOP;
    case (op)
      OP_WRITE: begin
        case (idx)
          3'd0: k = K_START;
          3'd1: k = K_ADDR_W;
          3'd2: k = K_REG;
          3'd3: k = K_DATA;
          default: k = K_STOP;
        endcase
      end
      OP_READ: begin
        case (idx)
          3'd0: k = K_START;
          3'd1: k = K_ADDR_W;
          3'd2: k = K_REG;
          3'd3: k = K_START;
          3'd4: k = K_ADDR_R;
          3'd5: k = K_RECV;
          default: k = K_STOP;
        endcase
      end
      default: begin
        case (idx)
          3'd0: k = K_START;
          3'd1: k = K_ADDR_W;
          default: k = K_STOP;
        endcase
      end
    endcase
    return k;
  endfunction

endpackage

// File: rtl/i2c_rm_tick.sv
module i2c_rm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= div;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  // R3: with a non-zero divider ticks never come back to back
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $past(div) == div) |=> !tick);

endmodule

// File: rtl/i2c_rm_sync.sv
module i2c_rm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_rm_pinmux.sv
module i2c_rm_pinmux (
  input  logic clk,
  input  logic rst,
  input  logic swap,
  input  logic scl_lo,
  input  logic sda_lo,
  input  logic a_s,
  input  logic b_s,
  output logic a_oe,
  output logic b_oe,
  output logic sda_s
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe <= 1'b0;
      b_oe <= 1'b0;
    end else if (swap) begin
      a_oe <= sda_lo;
      b_oe <= scl_lo;
    end else begin
      a_oe <= scl_lo;
      b_oe <= sda_lo;
    end
  end

  assign sda_s = swap ? a_s : b_s;

  // R2: the two pins are never driven from the same role at once when roles differ
  a_r2_role_split: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_lo) != $past(sda_lo) && $stable(swap)) |-> (a_oe != b_oe));

endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2c_rm_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             swap_pins,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [6:0]       cmd_dev,
  input  logic [7:0]       cmd_reg,
  input  logic [7:0]       cmd_wdata,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [7:0]       rdata,
  output logic             pin_a_oe,
  output logic             pin_b_oe,
  input  logic             pin_a_in,
  input  logic             pin_b_in
);

  localparam int QW = $clog2(START_QTRS);
  localparam int BW = $clog2(BYTE_BITS + 1);

  phase_e          state;
  logic [QW-1:0]   qcnt;
  logic [2:0]      step;
  logic [BW-1:0]   bit_idx;
  logic [7:0]      shreg;
  op_e             op_q;
  logic [6:0]      dev_q;
  logic [7:0]      reg_q;
  logic [7:0]      dat_q;
  logic            nack_q;

  logic            tick;
  logic            accept;
  logic            scl_lo;
  logic            sda_lo;
  logic            sda_s;
  logic [1:0]      pins_s;
  step_e           kind;
  step_e           next_kind;
  phase_e          next_phase;
  logic [7:0]      tx_byte;
  logic            is_rx;
  logic            bit_val;
  logic            last_q;

  assign accept = enable && cmd_valid && (state == ST_IDLE);

  i2c_rm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept || !enable),
    .div  (quarter_div),
    .tick (tick)
  );

  i2c_rm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pin_a_in, pin_b_in}),
    .q   (pins_s)
  );

  i2c_rm_pinmux u_pins (
    .clk    (clk),
    .rst    (rst),
    .swap   (swap_pins),
    .scl_lo (scl_lo),
    .sda_lo (sda_lo),
    .a_s    (pins_s[1]),
    .b_s    (pins_s[0]),
    .a_oe   (pin_a_oe),
    .b_oe   (pin_b_oe),
    .sda_s  (sda_s)
  );

  // element decode
  assign kind      = step_of(op_q, step);
  assign next_kind = step_of(op_q, step + 3'd1);
  assign is_rx     = (kind == K_RECV);

  always_comb begin
    case (next_kind)
      K_START: next_phase = ST_START;
      K_STOP:  next_phase = ST_STOP;
      default: next_phase = ST_BIT;
    endcase
  end

  always_comb begin
    case (kind)
      K_ADDR_W: tx_byte = {dev_q, 1'b0};
      K_ADDR_R: tx_byte = {dev_q, 1'b1};
      K_REG:    tx_byte = reg_q;
      K_DATA:   tx_byte = dat_q;
      default:  tx_byte = 8'hFF;
    endcase
  end

  // data bits MSB first; ninth slot and every received bit leave the line released
  assign bit_val = (bit_idx < BW'(BYTE_BITS) && !is_rx) ? tx_byte[3'd7 - bit_idx[2:0]] : 1'b1;

  assign last_q = (state == ST_START) ? (qcnt == QW'(START_QTRS - 1)) :
                  (state == ST_BIT)   ? (qcnt == QW'(BIT_QTRS - 1))   :
                                        (qcnt == QW'(STOP_QTRS - 1));

  // line levels per element and quarter
  always_comb begin
    scl_lo = 1'b0;
    sda_lo = 1'b0;
    case (state)
      ST_START: begin
        scl_lo = (qcnt == QW'(START_QTRS - 1));
        sda_lo = (qcnt >= QW'(START_QTRS - 2));
      end
      ST_BIT: begin
        scl_lo = (qcnt == QW'(0)) || (qcnt == QW'(BIT_QTRS - 1));
        sda_lo = !bit_val;
      end
      ST_STOP: begin
        scl_lo = (qcnt == QW'(0));
        sda_lo = (qcnt != QW'(STOP_QTRS - 1));
      end
      default: begin
        scl_lo = 1'b0;
        sda_lo = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      qcnt    <= '0;
      step    <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      op_q    <= OP_PROBE;
      dev_q   <= '0;
      reg_q   <= '0;
      dat_q   <= '0;
      nack_q  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
        qcnt  <= '0;
      end else if (accept) begin
        op_q    <= op_e'(cmd_op);
        dev_q   <= cmd_dev;
        reg_q   <= cmd_reg;
        dat_q   <= cmd_wdata;
        state   <= ST_START;
        step    <= '0;
        qcnt    <= '0;
        bit_idx <= '0;
        nack_q  <= 1'b0;
        busy    <= 1'b1;
      end else if (tick && state != ST_IDLE) begin
        if (state == ST_BIT && qcnt == QW'(2)) begin
          if (bit_idx < BW'(BYTE_BITS)) begin
            shreg <= {shreg[6:0], sda_s};
          end else if (!is_rx && sda_s) begin
            nack_q <= 1'b1;
          end
        end
        if (!last_q) begin
          qcnt <= qcnt + 1'b1;
        end else begin
          qcnt <= '0;
          case (state)
            ST_START: begin
              step    <= step + 3'd1;
              bit_idx <= '0;
              state   <= next_phase;
            end
            ST_BIT: begin
              if (bit_idx != BW'(BYTE_BITS)) begin
                bit_idx <= bit_idx + 1'b1;
              end else if (nack_q) begin
                state <= ST_STOP;
              end else begin
                step    <= step + 3'd1;
                bit_idx <= '0;
                state   <= next_phase;
              end
            end
            ST_STOP: begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
              fail  <= nack_q;
              if (op_q == OP_READ && !nack_q) rdata <= shreg;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: an accepted command raises busy on the next cycle
  a_r11_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && enable && !busy) |=> busy);

  // R11: busy and done are never high together
  a_r11_busy_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R12: disabling releases both line drivers and clears busy
  a_r12_release: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_lo && !sda_lo && !busy));

  // R4: inside a data bit the data line holds while the clock is high
  a_r4_sda_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BIT && $past(state) == ST_BIT && !scl_lo && !$past(scl_lo))
      |-> $stable(sda_lo));

  // R10: a failure is only reported together with completion
  a_r10_fail_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> done);

endmodule

// File: tb/tb_i2c_reg_master.sv
module tb_i2c_reg_master;

  localparam logic [6:0] SLV_ADDR = 7'h50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       swap = 1'b0;
  logic [15:0] qdiv = 16'd4;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [6:0] cmd_dev = 7'd0;
  logic [7:0] cmd_reg = 8'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       busy, done, fail;
  logic [7:0] rdata;
  logic       a_oe, b_oe;
  logic       a_in, b_in;

  // open-drain bus model with optional crossed wiring
  logic slv_lo = 1'b0;
  logic m_scl_oe, m_sda_oe, scl_l, sda_l;
  assign m_scl_oe = swap ? b_oe : a_oe;
  assign m_sda_oe = swap ? a_oe : b_oe;
  assign scl_l    = !m_scl_oe;
  assign sda_l    = !(m_sda_oe || slv_lo);
  assign a_in     = swap ? sda_l : scl_l;
  assign b_in     = swap ? scl_l : sda_l;

  always #2 clk = ~clk;

  i2c_reg_master dut (
    .clk(clk), .rst(rst), .enable(enable), .swap_pins(swap), .quarter_div(qdiv),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .fail(fail), .rdata(rdata),
    .pin_a_oe(a_oe), .pin_b_oe(b_oe), .pin_a_in(a_in), .pin_b_in(b_in)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // target and monitor state
  logic [7:0] mem [16];
  logic [7:0] rxb [8];
  int nrx, starts, stops, tmerr, ndone, nack_at, qexp;
  int cyc, t_rise, t_sdaf, bitc, byte_no;
  bit ps = 1'b1, psd = 1'b1, in_start, active, txm, ackph, rd_pend, mack;
  logic [7:0] sr, ptr, txb;
  logic s_c, s_d;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    nrx = 0; starts = 0; stops = 0; tmerr = 0; ndone = 0; mack = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      s_c = scl_l;
      s_d = sda_l;
      if (done) ndone++;
      if (ps && s_c && psd && !s_d) begin
        starts++; in_start = 1'b1; t_sdaf = cyc; active = 1'b1;
        bitc = 0; byte_no = 0; txm = 1'b0; ackph = 1'b0; rd_pend = 1'b0;
      end else if (ps && s_c && !psd && s_d) begin
        stops++;
        if (cyc - t_rise != 2 * qexp) tmerr++;
        active = 1'b0; slv_lo = 1'b0; txm = 1'b0;
      end else if (!ps && s_c) begin
        t_rise = cyc;
        if (active) begin
          if (bitc < 8) sr = {sr[6:0], s_d};
          else if (txm) mack = s_d;
          bitc++;
        end
      end else if (ps && !s_c) begin
        if (in_start) begin
          if (cyc - t_sdaf != qexp) tmerr++;
          in_start = 1'b0;
        end else if (cyc - t_rise != 2 * qexp) tmerr++;
        if (active) begin
          if (bitc == 8 && !ackph) begin
            ackph = 1'b1;
            if (txm) slv_lo = 1'b0;
            else begin
              if (nrx < 8) rxb[nrx] = sr;
              nrx++;
              if (byte_no == nack_at) begin
                slv_lo = 1'b0; active = 1'b0;
              end else if (byte_no == 0) begin
                if (sr[7:1] == SLV_ADDR) begin slv_lo = 1'b1; rd_pend = sr[0]; end
                else active = 1'b0;
              end else begin
                slv_lo = 1'b1;
                if (byte_no == 1) ptr = sr;
                else mem[ptr[3:0]] = sr;
              end
            end
          end else if (bitc == 9) begin
            bitc = 0; ackph = 1'b0; byte_no++; slv_lo = 1'b0; txm = 1'b0;
            if (rd_pend) begin
              rd_pend = 1'b0; txm = 1'b1; txb = mem[ptr[3:0]]; slv_lo = !txb[7];
            end
          end else if (txm && bitc >= 1 && bitc <= 7) begin
            slv_lo = !txb[7 - bitc];
          end
        end
      end
      ps = s_c;
      psd = s_d;
    end
  end

  task automatic step_clk();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [1:0] op, input logic [6:0] dev,
                       input logic [7:0] rg, input logic [7:0] wd);
    cmd_op = op; cmd_dev = dev; cmd_reg = rg; cmd_wdata = wd;
    cmd_valid = 1'b1;
    step_clk();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit got, output bit f, output logic [7:0] rd,
                           output bit bsy);
    got = 1'b0; f = 1'b0; rd = 8'h00; bsy = 1'b1;
    for (int n = 0; n < 8000; n++) begin
      if (done) begin
        got = 1'b1; f = fail; rd = rdata; bsy = busy;
        break;
      end
      step_clk();
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [6:0] dev, input logic [7:0] rg,
                     input logic [7:0] wd, output bit got, output bit f,
                     output logic [7:0] rd, output bit bsy);
    clear_mon();
    issue(op, dev, rg, wd);
    wait_done(got, f, rd, bsy);
    repeat (4) step_clk();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step_clk();
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    rst = 1'b0;
    enable = 1'b1;
    repeat (3) step_clk();
    chk(a_oe == 1'b0 && b_oe == 1'b0, "R1", "oe after reset", {a_oe, b_oe}, 0);
    chk(busy == 1'b0, "R1", "idle busy", busy, 0);
  endtask

  task automatic t_probe_ack();
    bit g, f, b; logic [7:0] rd;
    nack_at = -1;
    run(2'd0, SLV_ADDR, 8'h00, 8'h00, g, f, rd, b);
    chk(g && !f, "R7", "probe present fail", f, 0);
    chk(starts == 1 && stops == 1, "R7", "probe start/stop", starts * 16 + stops, 17);
    chk(nrx == 1 && rxb[0] == {SLV_ADDR, 1'b0}, "R6", "probe address byte", rxb[0], {SLV_ADDR, 1'b0});
    chk(!b, "R11", "busy low with done", b, 0);
  endtask

  task automatic t_probe_nack();
    bit g, f, b; logic [7:0] rd;
    nack_at = -1;
    run(2'd0, 7'h23, 8'h00, 8'h00, g, f, rd, b);
    chk(g && f, "R7", "probe absent fail", f, 1);
    chk(stops == 1, "R10", "stop after nack", stops, 1);
  endtask

  task automatic t_write(input logic [7:0] rg, input logic [7:0] wd, input string req);
    bit g, f, b; logic [7:0] rd;
    nack_at = -1;
    run(2'd1, SLV_ADDR, rg, wd, g, f, rd, b);
    chk(g && !f, req, "write fail flag", f, 0);
    chk(mem[rg[3:0]] == wd, req, "target register", mem[rg[3:0]], wd);
    chk(nrx == 3 && rxb[1] == rg && rxb[2] == wd, "R6", "byte order", {rxb[1], rxb[2]}, {rg, wd});
    chk(tmerr == 0, "R3", "bit/start/stop timing", tmerr, 0);
  endtask

  task automatic t_read(input logic [7:0] rg, input logic [7:0] val, input string req);
    bit g, f, b; logic [7:0] rd;
    nack_at = -1;
    mem[rg[3:0]] = val;
    run(2'd2, SLV_ADDR, rg, 8'h00, g, f, rd, b);
    chk(g && !f, req, "read fail flag", f, 0);
    chk(rd == val, req, "read data", rd, val);
    chk(starts == 2 && stops == 1, "R9", "repeated start", starts * 16 + stops, 33);
    chk(nrx == 3 && rxb[2] == {SLV_ADDR, 1'b1}, "R9", "read address byte", rxb[2], {SLV_ADDR, 1'b1});
    chk(mack == 1'b1, "R9", "master nack on read", mack, 1);
    chk(tmerr == 0, "R5", "stop/start timing", tmerr, 0);
  endtask

  task automatic t_nack_reg();
    bit g, f, b; logic [7:0] rd, keep;
    keep = 8'h77;
    mem[9] = keep;
    mem[4] = 8'h5A;
    nack_at = 1;
    run(2'd1, SLV_ADDR, 8'h09, 8'hE1, g, f, rd, b);
    chk(g && f, "R10", "offset nack fail", f, 1);
    chk(mem[9] == keep, "R10", "register untouched", mem[9], keep);
    chk(nrx == 2 && stops == 1, "R10", "bytes then stop", nrx * 16 + stops, 33);
    nack_at = 1;
    run(2'd2, SLV_ADDR, 8'h04, 8'h00, g, f, rd, b);
    chk(g && f && starts == 1, "R10", "read abort no restart", starts, 1);
    chk(rd == 8'hC3, "R10", "rdata kept", rd, 8'hC3);
    nack_at = -1;
  endtask

  task automatic t_busy();
    bit g, f, b; logic [7:0] rd;
    nack_at = -1;
    clear_mon();
    issue(2'd1, SLV_ADDR, 8'h06, 8'h3E);
    repeat (40) step_clk();
    chk(busy == 1'b1, "R11", "busy during transfer", busy, 1);
    issue(2'd0, 7'h11, 8'h00, 8'h00);
    wait_done(g, f, rd, b);
    repeat (600) step_clk();
    chk(ndone == 1 && starts == 1, "R11", "command while busy ignored", ndone * 16 + starts, 17);
    chk(!f && mem[6] == 8'h3E, "R11", "first command intact", mem[6], 8'h3E);
  endtask

  task automatic t_disable();
    bit g, f, b; logic [7:0] rd;
    nack_at = -1;
    clear_mon();
    issue(2'd2, SLV_ADDR, 8'h02, 8'h00);
    repeat (300) step_clk();
    enable = 1'b0;
    step_clk();
    step_clk();
    chk(a_oe == 1'b0 && b_oe == 1'b0, "R12", "lines released", {a_oe, b_oe}, 0);
    chk(busy == 1'b0, "R12", "busy cleared", busy, 0);
    cmd_op = 2'd0; cmd_dev = SLV_ADDR; cmd_valid = 1'b1;
    step_clk();
    cmd_valid = 1'b0;
    step_clk();
    chk(busy == 1'b0, "R11", "no accept while disabled", busy, 0);
    repeat (800) step_clk();
    chk(ndone == 0, "R12", "no done after abort", ndone, 0);
    enable = 1'b1;
    repeat (4) step_clk();
    run(2'd0, SLV_ADDR, 8'h00, 8'h00, g, f, rd, b);
    chk(g && !f, "R12", "recovery probe", f, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17);
    qexp = 5;
    nack_at = -1;
    t_reset();
    t_probe_ack();
    t_probe_nack();
    t_write(8'h03, 8'hA5, "R8");
    t_read(8'h05, 8'hC3, "R9");
    t_nack_reg();
    swap = 1'b1;
    repeat (4) step_clk();
    t_write(8'h0A, 8'h96, "R2");
    t_read(8'h0A, 8'h96, "R2");
    swap = 1'b0;
    qdiv = 16'd7;
    qexp = 8;
    repeat (4) step_clk();
    t_write(8'h0C, 8'h01, "R3");
    t_read(8'h0D, 8'h80, "R4");
    qdiv = 16'd4;
    qexp = 5;
    repeat (4) step_clk();
    t_busy();
    t_disable();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule